// File: doc/BRIEF.md
# I2C Control Register Target

This block is a write-only I2C target that holds the settings of a mixing and tone-control path. A host on the two-wire bus addresses it, names one register slot in a subaddress byte, and then streams data bytes into the slots. SCL and SDA are oversampled by the system clock, so the bus must run well below the system clock rate. SDA is driven as an open-drain pull-down. Every slot is presented in parallel on a flat output vector, so the analog control logic can read all settings at once.

The subaddress picks one of two write modes. With its top bit clear, each data byte up to the stop overwrites the same slot. With the top bit set, the slot index moves forward by one after each byte and wraps from 15 to 0. In this looping mode, bytes that land on slot numbers with no storage are dropped. They are still acknowledged, so a host that never checks acknowledges stays in step. Every stored slot comes up with a fixed default after reset.

Top module: `ctl_i2c_regbank`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Before the first start, the block ignores clocked bits and never drives SDA. A stop releases SDA and ends the transfer.
- R2: The block pulls SDA low during the ninth SCL pulse of each byte it accepts. It releases SDA after the SCL falling edge that ends that ninth pulse. The pull-down only begins while SCL is low.
- R3: The only byte acknowledged as an address is 0x80 (device address 1000000 with write bit 0). Any other address byte, 0x81 included, gets no acknowledge. The block then ignores the bus and writes nothing until the next start.
- R4: In the subaddress byte, bits 3:0 give the slot index and bit 7 selects the mode. Bits 6:4 have no effect.
- R5: With subaddress bit 7 = 0, every data byte before the stop is written to the one selected slot, so the last byte wins.
- R6: With subaddress bit 7 = 1, the first data byte goes to the selected index and each later byte goes to the previous index plus one. The 4-bit index wraps from 15 to 0.
- R7: Bytes aimed at index 2 or at indices 10 to 15 change no output, yet each is acknowledged. The bits for slot 2 always read 0x00.
- R8: A repeated start, sent without a stop, restarts address matching, including after an address that was not acknowledged.
- R9: After reset the slots read: 0 = 0x3F, 1 = 0x7E, 2 = 0x00, 3 = 0x0F, 4 = 0xFF, 5 through 8 = 0x7F (mute), 9 = 0x06.
- R10: Slot k appears on regs_o[8k+7:8k]. A slot changes only on the cycle after an accepted data byte is written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_low_o | output | 1 | High when the block pulls SDA low (acknowledge) |
| regs_o | output | SLOTS*8 (80) | All control slots, slot k at bits 8k+7:8k |

## Verification
The bench sends a looping write that starts at index 8. That write crosses the unstored range 10 to 15 and wraps into slots 0 and 1. A design that failed to skip those slots, or whose index counter saturated instead of wrapping, would corrupt other slots or leave slots 0 and 1 untouched. A second loop starts at slot 1 and steps over the unused slot 2, which shows that discarded bytes still move the index forward and are still acknowledged. Wrong addresses, a read address, and bits clocked before any start must produce no acknowledge and no write. A block that kept listening after a mismatch would store the trailing bytes. A repeated start after a rejected address must be accepted, which catches a design that only resets on a stop.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        phase_t             ph;
        logic [3:0]         cnt;
        logic [BYTE_W-1:0]  sh;
        logic               ack;
        logic [IDX_W-1:0]   idx;
        logic               loop;
        logic               we;
        logic [IDX_W-1:0]   widx;
        logic [BYTE_W-1:0]  wdat;
    } rx_t;

    function automatic logic [BYTE_W-1:0] slot_default(input int k);
        case (k)
            0:       return 8'h3F;
            1:       return 8'h7E;
            3:       return 8'h0F;
            4:       return 8'hFF;
            5, 6, 7, 8: return 8'h7F;
            9:       return 8'h06;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/ctl_i2c_sync.sv
module ctl_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh_d, scl_sh_q, sda_sh_d, sda_sh_q;
    logic              scl_p_d, scl_p_q, sda_p_d, sda_p_q;

    always_comb begin
        scl_sh_d = {scl_sh_q[STAGES-2:0], scl_i};
        sda_sh_d = {sda_sh_q[STAGES-2:0], sda_i};
        scl_p_d  = scl_sh_q[STAGES-1];
        sda_p_d  = sda_sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= scl_sh_d;
            sda_sh_q <= sda_sh_d;
            scl_p_q  <= scl_p_d;
            sda_p_q  <= sda_p_d;
        end
    end

    assign scl_s     = scl_sh_q[STAGES-1];
    assign sda_s     = sda_sh_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/ctl_i2c_rx.sv
module ctl_i2c_rx
    import ctl_i2c_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'b1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_low,
    output logic              ignoring,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_dat
);
    rx_t q, d;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (start_det) begin
            d.ph  = PH_ADDR;
            d.cnt = '0;
            d.ack = 1'b0;
        end else if (stop_det) begin
            d.ph  = PH_IDLE;
            d.cnt = '0;
            d.ack = 1'b0;
        end else if (q.ph == PH_ADDR || q.ph == PH_SUB || q.ph == PH_DATA) begin
            if (scl_rise && q.cnt < 4'd8) begin
                d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                d.cnt = q.cnt + 4'd1;
            end else if (scl_fall && q.cnt == 4'd8) begin
                d.cnt = 4'd9;
                case (q.ph)
                    PH_ADDR: begin
                        if (q.sh == {ADDR7, 1'b0}) begin
                            d.ack = 1'b1;
                        end else begin
                            d.ph  = PH_SKIP;
                            d.cnt = '0;
                        end
                    end
                    PH_SUB: begin
                        d.ack  = 1'b1;
                        d.idx  = q.sh[IDX_W-1:0];
                        d.loop = q.sh[BYTE_W-1];
                    end
                    default: begin
                        d.ack  = 1'b1;
                        d.we   = 1'b1;
                        d.widx = q.idx;
                        d.wdat = q.sh;
                        if (q.loop) begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                endcase
            end else if (scl_fall && q.cnt == 4'd9) begin
                d.ack = 1'b0;
                d.cnt = '0;
                if (q.ph == PH_ADDR) begin
                    d.ph = PH_SUB;
                end else if (q.ph == PH_SUB) begin
                    d.ph = PH_DATA;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_low  = q.ack;
    assign ignoring = (q.ph == PH_SKIP);
    assign wr_en    = q.we;
    assign wr_idx   = q.widx;
    assign wr_dat   = q.wdat;
endmodule

// File: rtl/ctl_i2c_bank.sv
module ctl_i2c_bank
    import ctl_i2c_pkg::*;
#(
    parameter int SLOTS = 10,
    parameter int HOLE  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]       wr_dat,
    output logic [SLOTS*BYTE_W-1:0] regs
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k == HOLE) begin : g_empty
            assign regs[k*BYTE_W +: BYTE_W] = '0;
        end else begin : g_store
            logic [BYTE_W-1:0] val_d, val_q;

            always_comb begin
                val_d = val_q;
                if (wr_en && wr_idx == IDX_W'(k)) begin
                    val_d = wr_dat;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= slot_default(k);
                end else begin
                    val_q <= val_d;
                end
            end

            assign regs[k*BYTE_W +: BYTE_W] = val_q;
        end
    end
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
    import ctl_i2c_pkg::*;
#(
    parameter logic [6:0] ADDR7     = 7'b1000000,
    parameter int         SLOTS     = 10,
    parameter int         HOLE      = 2,
    parameter int         SYNC_STGS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_low_o,
    output logic [SLOTS*BYTE_W-1:0] regs_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              ignoring, wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_dat;

    ctl_i2c_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    ctl_i2c_rx #(.ADDR7(ADDR7)) u_rx (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_low(sda_low_o), .ignoring(ignoring), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_dat(wr_dat)
    );

    ctl_i2c_bank #(.SLOTS(SLOTS), .HOLE(HOLE)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_dat(wr_dat), .regs(regs_o)
    );
endmodule

// File: rtl/ctl_i2c_regbank_chk.sv
module ctl_i2c_regbank_chk #(
    parameter int SLOTS = 10,
    parameter int HOLE  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sda_low,
    input logic                 scl_s,
    input logic                 stop_det,
    input logic                 ign,
    input logic                 wr_fire,
    input logic [3:0]           wr_idx,
    input logic [SLOTS*8-1:0]   regs
);
    a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(regs));

    a_r7_drop_high_index: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && int'(wr_idx) >= SLOTS) |=> $stable(regs));

    a_r7_drop_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && int'(wr_idx) == HOLE) |=> $stable(regs));

    a_r2_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> !scl_s);

    a_r3_silent_when_skipping: assert property (@(posedge clk) disable iff (!rst_n)
        ign |-> !sda_low);

    a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_low);
endmodule

bind ctl_i2c_regbank ctl_i2c_regbank_chk #(.SLOTS(SLOTS), .HOLE(HOLE)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_low(sda_low_o), .scl_s(scl_s),
    .stop_det(stop_det), .ign(ignoring), .wr_fire(wr_en), .wr_idx(wr_idx),
    .regs(regs_o)
);

// File: tb/ctl_i2c_regbank_test.sv
module ctl_i2c_regbank_test;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_low;
    logic [79:0] regs;
    wire         sda_bus = sda_m & ~sda_low;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  mdl [0:9];
    logic [79:0] img_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    ctl_i2c_regbank uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_low_o(sda_low), .regs_o(regs)
    );

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    function automatic logic [79:0] image();
        logic [79:0] v;
        for (int k = 0; k < 10; k++) v[k*8 +: 8] = mdl[k];
        return v;
    endfunction

    task automatic expect_regs(input string tag);
        img_q.push_back(image());
        tag_q.push_back(tag);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
        chk("R1 SDA released after stop", {79'b0, sda_low}, 80'd0);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        logic got;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait();
            scl_m = 1'b1; qwait(); qwait();
            scl_m = 1'b0; qwait();
        end
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        got = ~sda_bus;
        qwait();
        scl_m = 1'b0;
        chk({req, " acknowledge"}, {79'b0, got}, {79'b0, exp_ack});
        qwait();
        chk("R2 release after ninth clock", {79'b0, sda_low}, 80'd0);
    endtask

    // Scoreboard monitor: compares each expected image against the outputs.
    initial begin
        forever begin
            wait (img_q.size() > 0);
            @(negedge clk);
            chk(tag_q.pop_front(), regs, img_q.pop_front());
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        mdl[0] = 8'h3F; mdl[1] = 8'h7E; mdl[2] = 8'h00; mdl[3] = 8'h0F;
        mdl[4] = 8'hFF; mdl[5] = 8'h7F; mdl[6] = 8'h7F; mdl[7] = 8'h7F;
        mdl[8] = 8'h7F; mdl[9] = 8'h06;
        repeat (5) @(negedge clk);
        chk("R2 no drive in reset", {79'b0, sda_low}, 80'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        expect_regs("R9 reset defaults");

        // R1: a byte clocked with no start is ignored.
        send_byte(8'h80, 1'b0, "R1 no start");
        send_byte(8'h04, 1'b0, "R1 no start");
        send_byte(8'h12, 1'b0, "R1 no start");
        bus_stop();
        expect_regs("R1 nothing written without start");

        // R5 + R4: single-slot mode, bits 6:4 set.
        bus_start();
        send_byte(8'h80, 1'b1, "R3 address");
        send_byte(8'h74, 1'b1, "R4 subaddress");
        send_byte(8'h11, 1'b1, "R5 data");
        send_byte(8'h22, 1'b1, "R5 data");
        send_byte(8'h33, 1'b1, "R5 data");
        bus_stop();
        mdl[4] = 8'h33;
        expect_regs("R5 last byte wins");

        // R6 + R7: loop from 8 over 10..15, wrap to 0 and 1.
        bus_start();
        send_byte(8'h80, 1'b1, "R3 address");
        send_byte(8'h88, 1'b1, "R6 subaddress");
        send_byte(8'hA8, 1'b1, "R6 data");
        send_byte(8'hA9, 1'b1, "R6 data");
        for (int j = 0; j < 6; j++) send_byte(8'hE0 + 8'(j), 1'b1, "R7 discarded data");
        send_byte(8'hB0, 1'b1, "R6 wrapped data");
        send_byte(8'hB1, 1'b1, "R6 wrapped data");
        bus_stop();
        mdl[8] = 8'hA8; mdl[9] = 8'hA9; mdl[0] = 8'hB0; mdl[1] = 8'hB1;
        expect_regs("R6 loop with skip and wrap");

        // R7: direct write to the unused slot.
        bus_start();
        send_byte(8'h80, 1'b1, "R3 address");
        send_byte(8'h02, 1'b1, "R7 subaddress");
        send_byte(8'h5A, 1'b1, "R7 hole data");
        bus_stop();
        expect_regs("R7 unused slot unchanged");

        // R6 + R7: loop from 1 steps over slot 2.
        bus_start();
        send_byte(8'h80, 1'b1, "R3 address");
        send_byte(8'hF1, 1'b1, "R4 subaddress");
        send_byte(8'h21, 1'b1, "R6 data");
        send_byte(8'h22, 1'b1, "R7 hole data");
        send_byte(8'h23, 1'b1, "R6 data");
        bus_stop();
        mdl[1] = 8'h21; mdl[3] = 8'h23;
        expect_regs("R6 index advances past hole");

        // R6: wrap 14, 15 -> 0.
        bus_start();
        send_byte(8'h80, 1'b1, "R3 address");
        send_byte(8'h8E, 1'b1, "R6 subaddress");
        send_byte(8'hC0, 1'b1, "R7 discarded data");
        send_byte(8'hC1, 1'b1, "R7 discarded data");
        send_byte(8'hC2, 1'b1, "R6 wrapped data");
        bus_stop();
        mdl[0] = 8'hC2;
        expect_regs("R6 wrap 15 to 0");

        // R3: wrong address, then bytes that must not be stored.
        bus_start();
        send_byte(8'h82, 1'b0, "R3 wrong address");
        send_byte(8'h05, 1'b0, "R3 ignored byte");
        send_byte(8'h66, 1'b0, "R3 ignored byte");
        bus_stop();
        expect_regs("R3 nothing written after mismatch");

        // R3: read direction is refused.
        bus_start();
        send_byte(8'h81, 1'b0, "R3 read address");
        send_byte(8'h07, 1'b0, "R3 ignored byte");
        bus_stop();
        expect_regs("R3 nothing written after read address");

        // R8: repeated start after a rejected address.
        bus_start();
        send_byte(8'h90, 1'b0, "R8 rejected address");
        bus_start();
        send_byte(8'h80, 1'b1, "R8 address after repeated start");
        send_byte(8'h06, 1'b1, "R8 subaddress");
        send_byte(8'h44, 1'b1, "R8 data");
        bus_stop();
        mdl[6] = 8'h44;
        expect_regs("R8 write after repeated start");

        wait (img_q.size() == 0);
        repeat (4) @(negedge clk);
        chk("R10 slot 2 field", {72'b0, regs[23:16]}, 80'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule